// File: doc/BRIEF.md
# Five-Stage In-Order Load/Store Pipeline

This block is a small in-order integer pipeline. It has five stages: fetch, decode, execute, memory access and register writeback. A register sits between each pair of stages. The instruction store and the data store are synchronous arrays inside the block, and a test environment fills them while reset is held. The core executes four operations on an eight-entry register file: add, bitwise nand, word load and word store. It has no branches, so the program counter walks forward one word per cycle.

Bypassing is not implemented. Instead, a separate interlock unit compares the source fields in decode against the destinations still in flight. On a match it freezes fetch and decode and pushes a bubble into execute. The outside world sees the register file through a read-only debug port, and a strobe that marks every real instruction as it completes.

Top module: `pipe5_core`

## Requirements
- R1: While reset is low and in the cycle reset is released, `retire_o` is 0 and every register reads 0 through the debug port. All stage registers hold nops.
- R2: Take the first cycle after reset release as cycle 1. The instruction at word 0 retires in cycle 5. Instructions with no dependence on an instruction still in flight retire in consecutive cycles.
- R3: add (opcode 1) writes the sum of registers ra and rb to rd, modulo 2^32.
- R4: nand (opcode 2) writes the complement of (ra AND rb) to rd. For example, 18 nand 7 gives -3.
- R5: A load (opcode 3) writes to rd the data word at byte address ra + sign-extended imm. The word index is address bits [7:2]. Negative offsets work.
- R6: A store (opcode 4) writes register rb to the data word at ra + sign-extended imm. A later load from that address returns the stored value. A store writes no register.
- R7: Register 0 always reads 0. Any instruction whose destination is register 0 leaves all registers unchanged.
- R8: An instruction in decode that reads a nonzero register is held in decode while that register is the destination of a writing instruction in execute or memory. For each held cycle one bubble enters execute, and the program counter does not move. The held instruction leaves decode in the writeback cycle of its producer and retires three cycles later.
- R9: A register written by writeback in a cycle is read by decode in that same cycle with its new value. A consumer three instructions behind its producer is therefore not held.
- R10: `retire_o` is high for exactly one cycle per non-nop instruction (stores included), in its writeback cycle. It stays low for nops and bubbles.
- R11: Instruction encoding: opcode in bits [31:26] (0 = nop), ra in [25:23], rb in [22:20], rd in [19:17], and a 17-bit signed immediate in [16:0]. Unknown opcodes act as nop.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dbg_addr_i | input | $clog2(NREG) | Register index for the debug read |
| dbg_data_o | output | XLEN | Committed value of the selected register |
| retire_o | output | 1 | High in the writeback cycle of each real instruction |

## Verification
The hardest cases to reach are the two timing edges of the interlock. The first is a consumer right behind a load, which must stall for two cycles. The second is a consumer exactly three slots behind its producer, which must not stall because the register file passes the written value through in the same cycle. The programs are built so that both cases occur, including a store whose data register comes from the instruction just before it. A behavioural model places each instruction's decode cycle from the writeback cycles of its producers. The bench then compares the retire strobe and all eight registers against that model on every cycle, so a stall that is one cycle too long or too short shows up as a mismatch.

// File: rtl/pipe5_pkg.sv
package pipe5_pkg;
  localparam int ILEN    = 32;
  localparam int OPC_LSB = 26;

  typedef enum logic [5:0] {
    OP_NOP  = 6'd0,
    OP_ADD  = 6'd1,
    OP_NAND = 6'd2,
    OP_LW   = 6'd3,
    OP_SW   = 6'd4
  } op_e;

  typedef struct packed {
    op_e  op;
    logic rf_we;
    logic mem_we;
    logic is_load;
    logic use_a;
    logic use_b;
  } ctrl_t;

  localparam ctrl_t CTRL_NOP = '{op: OP_NOP, rf_we: 1'b0, mem_we: 1'b0,
                                 is_load: 1'b0, use_a: 1'b0, use_b: 1'b0};

  function automatic ctrl_t decode_op(logic [5:0] opc);
    ctrl_t c;
    c = CTRL_NOP;
    case (opc)
      6'd1: begin c.op = OP_ADD;  c.rf_we = 1'b1; c.use_a = 1'b1; c.use_b = 1'b1; end
      6'd2: begin c.op = OP_NAND; c.rf_we = 1'b1; c.use_a = 1'b1; c.use_b = 1'b1; end
      6'd3: begin c.op = OP_LW;   c.rf_we = 1'b1; c.is_load = 1'b1; c.use_a = 1'b1; end
      6'd4: begin c.op = OP_SW;   c.mem_we = 1'b1; c.use_a = 1'b1; c.use_b = 1'b1; end
      default: c = CTRL_NOP;
    endcase
    return c;
  endfunction
endpackage

// File: rtl/pipe5_mem.sv
module pipe5_mem #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 64
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       rd_en_i,
  input  logic                       we_i,
  input  logic [$clog2(DEPTH)-1:0]   addr_i,
  input  logic [WIDTH-1:0]           wdata_i,
  output logic [WIDTH-1:0]           rdata_o
);
  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  // registered read port doubles as the downstream stage register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mem_q[addr_i];
  end
endmodule

// File: rtl/pipe5_regfile.sv
module pipe5_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      we_i,
  input  logic [$clog2(NREG)-1:0]   waddr_i,
  input  logic [XLEN-1:0]           wdata_i,
  input  logic [$clog2(NREG)-1:0]   ra_addr_i,
  input  logic [$clog2(NREG)-1:0]   rb_addr_i,
  output logic [XLEN-1:0]           ra_data_o,
  output logic [XLEN-1:0]           rb_data_o,
  input  logic [$clog2(NREG)-1:0]   dbg_addr_i,
  output logic [XLEN-1:0]           dbg_data_o
);
  localparam int RW = $clog2(NREG);

  logic [XLEN-1:0] rd_view [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    if (g == 0) begin : g_zero
      assign rd_view[g] = '0;
    end else begin : g_live
      logic [XLEN-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                           q <= '0;
        else if (we_i && waddr_i == RW'(g))    q <= wdata_i;
      end
      assign rd_view[g] = q;
    end
  end

  // write-before-read: same-cycle writeback is visible to decode
  assign ra_data_o = (we_i && ra_addr_i == waddr_i && ra_addr_i != '0) ? wdata_i : rd_view[ra_addr_i];
  assign rb_data_o = (we_i && rb_addr_i == waddr_i && rb_addr_i != '0) ? wdata_i : rd_view[rb_addr_i];
  assign dbg_data_o = rd_view[dbg_addr_i];

  p_write_lands_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && waddr_i != '0) |=> (rd_view[$past(waddr_i)] == $past(wdata_i)));
endmodule

// File: rtl/pipe5_hazard.sv
module pipe5_hazard #(
  parameter int RW = 3
) (
  input  logic          id_use_a_i,
  input  logic          id_use_b_i,
  input  logic [RW-1:0] id_ra_i,
  input  logic [RW-1:0] id_rb_i,
  input  logic          ex_we_i,
  input  logic [RW-1:0] ex_rd_i,
  input  logic          mem_we_i,
  input  logic [RW-1:0] mem_rd_i,
  output logic          stall_o
);
  localparam int NPEND = 2;  // execute and memory; writeback is covered by write-before-read

  logic [NPEND-1:0] pend_we;
  logic [RW-1:0]    pend_rd [NPEND];
  logic [NPEND-1:0] hit;

  assign pend_we    = {mem_we_i, ex_we_i};
  assign pend_rd[0] = ex_rd_i;
  assign pend_rd[1] = mem_rd_i;

  for (genvar g = 0; g < NPEND; g++) begin : g_cmp
    assign hit[g] = pend_we[g] &&
                    ((id_use_a_i && id_ra_i != '0 && id_ra_i == pend_rd[g]) ||
                     (id_use_b_i && id_rb_i != '0 && id_rb_i == pend_rd[g]));
  end

  assign stall_o = |hit;

  always_comb begin
    if (stall_o) begin
      p_stall_needs_source_r8: assert (id_use_a_i || id_use_b_i);
    end
  end
endmodule

// File: rtl/pipe5_core.sv
module pipe5_core
  import pipe5_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 8,
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [$clog2(NREG)-1:0]  dbg_addr_i,
  output logic [XLEN-1:0]          dbg_data_o,
  output logic                     retire_o
);
  localparam int RW     = $clog2(NREG);
  localparam int IAW    = $clog2(IMEM_WORDS);
  localparam int DAW    = $clog2(DMEM_WORDS);
  localparam int RA_LSB = OPC_LSB - RW;
  localparam int RB_LSB = RA_LSB - RW;
  localparam int RD_LSB = RB_LSB - RW;
  localparam int IMMW   = RD_LSB;

  logic hold;

  // ---------------- fetch ----------------
  logic [IAW-1:0]  pc_q;  // word index, byte PC is {pc_q, 2'b00}
  logic [ILEN-1:0] fd_inst;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pc_q <= '0;
    else if (!hold) pc_q <= pc_q + 1'b1;
  end

  pipe5_mem #(.WIDTH(ILEN), .DEPTH(IMEM_WORDS)) u_imem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (!hold),
    .we_i    (1'b0),
    .addr_i  (pc_q),
    .wdata_i ('0),
    .rdata_o (fd_inst)
  );

  // ---------------- decode ----------------
  ctrl_t           id_ctrl;
  logic [RW-1:0]   id_ra, id_rb, id_rd;
  logic [XLEN-1:0] id_imm, id_a, id_b;
  logic            id_rf_we;

  logic            wb_we;
  logic [RW-1:0]   wb_rd;
  logic [XLEN-1:0] wb_data;

  assign id_ctrl  = decode_op(fd_inst[ILEN-1:OPC_LSB]);
  assign id_ra    = fd_inst[RA_LSB +: RW];
  assign id_rb    = fd_inst[RB_LSB +: RW];
  assign id_rd    = fd_inst[RD_LSB +: RW];
  assign id_imm   = {{(XLEN-IMMW){fd_inst[IMMW-1]}}, fd_inst[IMMW-1:0]};
  assign id_rf_we = id_ctrl.rf_we && (id_rd != '0);

  pipe5_regfile #(.XLEN(XLEN), .NREG(NREG)) u_rf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (wb_we),
    .waddr_i    (wb_rd),
    .wdata_i    (wb_data),
    .ra_addr_i  (id_ra),
    .rb_addr_i  (id_rb),
    .ra_data_o  (id_a),
    .rb_data_o  (id_b),
    .dbg_addr_i (dbg_addr_i),
    .dbg_data_o (dbg_data_o)
  );

  logic            de_valid, de_rf_we, de_mem_we, de_is_load;
  op_e             de_op;
  logic [RW-1:0]   de_rd;
  logic [XLEN-1:0] de_imm, de_a, de_b;

  logic            em_valid, em_rf_we, em_mem_we, em_is_load;
  logic [RW-1:0]   em_rd;
  logic [XLEN-1:0] em_alu, em_b;

  pipe5_hazard #(.RW(RW)) u_hazard (
    .id_use_a_i (id_ctrl.use_a),
    .id_use_b_i (id_ctrl.use_b),
    .id_ra_i    (id_ra),
    .id_rb_i    (id_rb),
    .ex_we_i    (de_rf_we),
    .ex_rd_i    (de_rd),
    .mem_we_i   (em_rf_we),
    .mem_rd_i   (em_rd),
    .stall_o    (hold)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      de_valid <= 1'b0; de_op <= OP_NOP; de_rf_we <= 1'b0; de_mem_we <= 1'b0;
      de_is_load <= 1'b0; de_rd <= '0; de_imm <= '0; de_a <= '0; de_b <= '0;
    end else if (hold) begin
      // bubble: nop with every write enable cleared
      de_valid <= 1'b0; de_op <= OP_NOP; de_rf_we <= 1'b0; de_mem_we <= 1'b0;
      de_is_load <= 1'b0;
    end else begin
      de_valid   <= (id_ctrl.op != OP_NOP);
      de_op      <= id_ctrl.op;
      de_rf_we   <= id_rf_we;
      de_mem_we  <= id_ctrl.mem_we;
      de_is_load <= id_ctrl.is_load;
      de_rd      <= id_rd;
      de_imm     <= id_imm;
      de_a       <= id_a;
      de_b       <= id_b;
    end
  end

  // ---------------- execute ----------------
  logic [XLEN-1:0] ex_alu;

  always_comb begin
    case (de_op)
      OP_ADD:  ex_alu = de_a + de_b;
      OP_NAND: ex_alu = ~(de_a & de_b);
      default: ex_alu = de_a + de_imm;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      em_valid <= 1'b0; em_rf_we <= 1'b0; em_mem_we <= 1'b0; em_is_load <= 1'b0;
      em_rd <= '0; em_alu <= '0; em_b <= '0;
    end else begin
      em_valid   <= de_valid;
      em_rf_we   <= de_rf_we;
      em_mem_we  <= de_mem_we;
      em_is_load <= de_is_load;
      em_rd      <= de_rd;
      em_alu     <= ex_alu;
      em_b       <= de_b;
    end
  end

  // ---------------- memory ----------------
  logic            mw_valid, mw_rf_we, mw_is_load;
  logic [RW-1:0]   mw_rd;
  logic [XLEN-1:0] mw_alu, mw_ldata;

  pipe5_mem #(.WIDTH(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .rd_en_i (1'b1),
    .we_i    (em_mem_we),
    .addr_i  (em_alu[DAW+1:2]),
    .wdata_i (em_b),
    .rdata_o (mw_ldata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mw_valid <= 1'b0; mw_rf_we <= 1'b0; mw_is_load <= 1'b0; mw_rd <= '0; mw_alu <= '0;
    end else begin
      mw_valid   <= em_valid;
      mw_rf_we   <= em_rf_we;
      mw_is_load <= em_is_load;
      mw_rd      <= em_rd;
      mw_alu     <= em_alu;
    end
  end

  // ---------------- writeback ----------------
  assign wb_we    = mw_rf_we;
  assign wb_rd    = mw_rd;
  assign wb_data  = mw_is_load ? mw_ldata : mw_alu;
  assign retire_o = mw_valid;

  p_stall_bubble_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> (!de_valid && !de_rf_we && !de_mem_we));

  p_stall_freezes_fetch_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold |=> ($stable(pc_q) && $stable(fd_inst)));

  p_store_no_regwrite_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    em_mem_we |=> (mw_valid && !mw_rf_we));

  p_no_r0_write_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_rf_we |-> (mw_rd != '0));
endmodule

// File: tb/tb_pipe5_core.sv
module tb_pipe5_core;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  dbg_addr = '0;
  logic [31:0] dbg_data;
  logic        retire;

  always #10 clk = ~clk;  // 50 MHz

  pipe5_core dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .dbg_addr_i (dbg_addr),
    .dbg_data_o (dbg_data),
    .retire_o   (retire)
  );

  localparam int MAXI = 32;
  localparam int OADD = 1, ONAND = 2, OLW = 3, OSW = 4;

  int          n_chk = 0, n_fail = 0;
  int          n_ins;
  int          p_op [MAXI], p_ra [MAXI], p_rb [MAXI], p_rd [MAXI], p_imm [MAXI];
  string       p_tag [MAXI];
  logic [31:0] dinit [64];

  int          dec_c [MAXI], wb_c [MAXI];
  logic [31:0] res [MAXI];
  bit          wr [MAXI];
  string       ttag [MAXI];
  int          last_wb;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp, string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, $signed(act), $signed(exp));
    end
  endtask

  task automatic clear_prog();
    n_ins = 0;
    for (int i = 0; i < 64; i++) dinit[i] = '0;
  endtask

  task automatic put(int op, int ra, int rb, int rd, int imm, string tag);
    p_op[n_ins] = op; p_ra[n_ins] = ra; p_rb[n_ins] = rb;
    p_rd[n_ins] = rd; p_imm[n_ins] = imm; p_tag[n_ins] = tag;
    n_ins++;
  endtask

  // R11 field layout
  function automatic logic [31:0] enc(int i);
    return {6'(p_op[i]), 3'(p_ra[i]), 3'(p_rb[i]), 3'(p_rd[i]), 17'(p_imm[i])};
  endfunction

  task automatic build_model();
    logic [31:0] m [8];
    logic [31:0] dm [64];
    int prev;
    for (int r = 0; r < 8; r++) m[r] = '0;
    for (int k = 0; k < 64; k++) dm[k] = dinit[k];
    prev = 1;
    for (int i = 0; i < n_ins; i++) begin
      bit ua, ub, r9hit;
      int d;
      logic [31:0] a, b, ad;
      ua = 1'b1;
      ub = (p_op[i] != OLW);
      d = prev + 1;
      r9hit = 1'b0;
      for (int p = 0; p < i; p++) begin
        if (wr[p] && p_rd[p] != 0 &&
            ((ua && p_ra[p] == p_rd[p] && 0) || (ua && p_ra[i] == p_rd[p]) || (ub && p_rb[i] == p_rd[p]))) begin
          if (wb_c[p] > d) d = wb_c[p];
        end
      end
      for (int p = 0; p < i; p++) begin
        if (wr[p] && p_rd[p] != 0 && wb_c[p] == d &&
            ((ua && p_ra[i] == p_rd[p]) || (ub && p_rb[i] == p_rd[p]))) r9hit = 1'b1;
      end
      dec_c[i] = d;
      wb_c[i]  = d + 3;
      if (d > prev + 1) ttag[i] = "R8";
      else if (r9hit)   ttag[i] = "R9";
      else              ttag[i] = "R2";
      prev = d;
      a  = m[p_ra[i]];
      b  = m[p_rb[i]];
      ad = a + 32'(p_imm[i]);
      wr[i] = (p_op[i] != OSW);
      case (p_op[i])
        OADD:    res[i] = a + b;
        ONAND:   res[i] = ~(a & b);
        OLW:     res[i] = dm[ad[7:2]];
        default: begin res[i] = '0; dm[ad[7:2]] = b; end
      endcase
      if (wr[i] && p_rd[i] != 0) m[p_rd[i]] = res[i];
    end
    last_wb = wb_c[n_ins-1];
  endtask

  task automatic run_prog();
    rst_ni = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 64; i++) begin
      dut.u_imem.mem_q[i] = (i < n_ins) ? enc(i) : 32'h0;
      dut.u_dmem.mem_q[i] = dinit[i];
    end
    build_model();
    @(negedge clk);
    check("R1", 32'(retire), 32'h0, "retire in reset");
    for (int r = 0; r < 8; r++) begin
      dbg_addr = 3'(r); #1;
      check("R1", dbg_data, 32'h0, $sformatf("reg %0d in reset", r));
    end
    @(negedge clk);
    rst_ni = 1'b1;
    for (int c = 1; c <= last_wb + 3; c++) begin
      logic exp_ret;
      string rt;
      exp_ret = 1'b0;
      rt = (c == 1) ? "R1" : "R10";
      for (int i = 0; i < n_ins; i++)
        if (wb_c[i] == c) begin exp_ret = 1'b1; rt = {ttag[i], " R10"}; end
      check(rt, 32'(retire), 32'(exp_ret), $sformatf("retire cycle %0d", c));
      for (int r = 0; r < 8; r++) begin
        logic [31:0] ev;
        string tg;
        ev = '0;
        tg = (r == 0) ? "R7" : "R1";
        for (int i = 0; i < n_ins; i++)
          if (wr[i] && p_rd[i] == r && r != 0 && wb_c[i] < c) begin ev = res[i]; tg = p_tag[i]; end
        dbg_addr = 3'(r); #1;
        check(tg, dbg_data, ev, $sformatf("reg %0d cycle %0d", r, c));
      end
      @(negedge clk);
    end
  endtask

  initial begin
    #(20 * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    // program 1: loads, load-use stalls, nand example, r0 writes, store then load
    clear_prog();
    dinit[0] = 36; dinit[1] = 9; dinit[2] = 18; dinit[3] = 7;
    put(OLW,   0, 0, 1, 0,  "R5");
    put(OLW,   0, 0, 2, 4,  "R5");
    put(OLW,   0, 0, 4, 8,  "R5");
    put(OLW,   0, 0, 5, 12, "R5");
    put(OADD,  1, 2, 3, 0,  "R3 R11");
    put(ONAND, 4, 5, 6, 0,  "R4");
    put(OADD,  1, 1, 0, 0,  "R7");
    put(OSW,   0, 6, 0, 20, "R6");
    put(OLW,   0, 0, 7, 20, "R6");
    put(OADD,  7, 0, 2, 0,  "R7 R3");
    put(ONAND, 1, 1, 1, 0,  "R4");
    run_prog();

    // program 2: back-to-back independent work and distance-3 consumers (R9)
    clear_prog();
    dinit[0] = 5; dinit[1] = 3; dinit[2] = 32'hF0F0_00FF;
    put(OLW,   0, 0, 1, 0, "R5");
    put(OLW,   0, 0, 2, 4, "R5");
    put(OLW,   0, 0, 3, 8, "R5");
    put(OADD,  1, 1, 4, 0, "R3 R9");
    put(OADD,  2, 2, 5, 0, "R3 R9");
    put(ONAND, 1, 3, 6, 0, "R4");
    put(OADD,  3, 3, 7, 0, "R3");
    run_prog();

    // program 3: negative offsets, store data hazard, overwrite via store
    clear_prog();
    dinit[2] = 100; dinit[3] = 77; dinit[4] = 16;
    put(OLW,   0, 0, 4, 16, "R5");
    put(OLW,   4, 0, 5, -8, "R5");
    put(OSW,   4, 5, 0, -4, "R6");
    put(OLW,   0, 0, 6, 12, "R6");
    put(ONAND, 6, 6, 7, 0,  "R4");
    put(OADD,  7, 4, 3, 0,  "R3");
    put(OADD,  3, 3, 0, 0,  "R7");
    run_prog();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule